// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This block runs the SHA-1 compression function over a message that has already been padded and split into 512-bit blocks. A start pulse latches how many blocks follow and loads the initial hash into both the running hash and the working registers a, b, c, d, e. The engine then requests message words and takes one word per cycle while the word-valid input is high. Each word it takes drives one round straight away, so the first 16 rounds overlap the fetch. The remaining 64 schedule words come from a 16-word sliding window. That window computes each new word from the rotated XOR of four older entries in the same cycle as the round that uses it.

After round 79, one accumulation cycle adds the working words into the running hash modulo 2^32. If more blocks remain, the engine goes back to fetching words. When the last block is done, it raises done for one cycle. The 160-bit digest stays on its output until the next accepted start.

The controller has five states. IDLE waits for start. LOAD covers rounds 0 to 15 and advances only when a word is offered. EXPAND covers rounds 16 to 79, one per cycle. ACCUM folds the block result into the hash. DONE drives the completion pulse. The transitions are:
- IDLE→LOAD on start with a nonzero block count.
- IDLE→DONE on start with a zero count.
- LOAD→EXPAND when word 15 is taken.
- EXPAND→ACCUM after round 79.
- ACCUM→LOAD when blocks remain.
- ACCUM→DONE after the last block.
- DONE→IDLE always.

Top module: `sha1_block_engine`

## Requirements
- R1: After reset, done_o and want_word_o are low and digest_o equals 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0, with word a in bits 159:128 and word e in bits 31:0.
- R2: While want_word_o is high, a word is taken only in a cycle where word_valid_i is high; a cycle without it leaves the round position unchanged and keeps want_word_o high.
- R3: Rounds 16 to 79 advance exactly one round per clock with no input needed, using the schedule word rotl1(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16]).
- R4: Rounds use Ch with constant 5A827999 for 0-19, Parity with 6ED9EBA1 for 20-39, Maj with 8F1BBCDC for 40-59, and Parity with CA62C1D6 for 60-79. Each round computes rotl5(a)+f+e+K+w, then shifts the state as e=d, d=c, c=rotl30(b), b=a, a=temp. For the single-block message "abc" the digest is A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R5: After each block the five working words are added modulo 2^32 into the hash, and the sum seeds the next block. The digest of an N-block message equals chained compression from the initial hash.
- R6: With a word offered in every requesting cycle, done_o is high in the cycle that follows 81*N rising edges after the edge that accepts start (243 for three blocks).
- R7: done_o is high for exactly one cycle per accepted start.
- R8: digest_o holds its value from done_o until the next accepted start.
- R9: start_i is ignored while a message is in progress.
- R10: A start with a block count of zero raises done_o on the next cycle, with digest_o equal to the initial hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a message (accepted in IDLE only) |
| n_blocks_i | input | CNT_W | Number of 512-bit blocks, sampled with start |
| want_word_o | output | 1 | Engine is requesting a message word |
| word_valid_i | input | 1 | word_i carries the next message word |
| word_i | input | 32 | Message word, big-endian order within the block |
| done_o | output | 1 | One-cycle completion pulse |
| digest_o | output | 160 | Running hash, final digest after done |

## Verification
All results are due a fixed number of edges after start. A word offered while the engine requests one is taken at the next rising edge. Each block costs 16 fetch edges, 64 expansion edges and one accumulation edge, and done appears after the edge that completes the last accumulation. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the first one after the start edge, so it can compare the edge count at which done is seen against 81*N, or against 0 for an empty message. It reads the digest in that same half cycle, checks that done has dropped one edge later, and checks again after several idle edges.

// File: rtl/sha1_pkg.sv
package sha1_pkg;

    localparam int WORD_W   = 32;
    localparam int N_ROUNDS = 80;
    localparam int WIN_LEN  = 16;
    localparam int RND_W    = $clog2(N_ROUNDS + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_EXPAND,
        S_ACCUM,
        S_DONE
    } eng_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] e;
    } hash_words_t;

    localparam hash_words_t HASH_IV = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Boolean mixer picked by round range
    function automatic logic [WORD_W-1:0] mix_f(input logic [RND_W-1:0] rnd,
                                               input logic [WORD_W-1:0] x,
                                               input logic [WORD_W-1:0] y,
                                               input logic [WORD_W-1:0] z);
        if (rnd < 20)      return (x & y) | (~x & z);
        else if (rnd < 40) return x ^ y ^ z;
        else if (rnd < 60) return (x & y) | (x & z) | (y & z);
        else               return x ^ y ^ z;
    endfunction

    function automatic logic [WORD_W-1:0] mix_k(input logic [RND_W-1:0] rnd);
        if (rnd < 20)      return 32'h5A827999;
        else if (rnd < 40) return 32'h6ED9EBA1;
        else if (rnd < 60) return 32'h8F1BBCDC;
        else               return 32'hCA62C1D6;
    endfunction

endpackage

// File: rtl/sha1_sched_window.sv
module sha1_sched_window
    import sha1_pkg::*;
#(
    parameter int DEPTH = WIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              use_ext_i,
    input  logic [WORD_W-1:0] ext_word_i,
    output logic [WORD_W-1:0] w_o
);
    // slot k holds w[i-DEPTH+k] when round i is current
    localparam int TAP_3  = DEPTH - 3;
    localparam int TAP_8  = DEPTH - 8;
    localparam int TAP_14 = DEPTH - 14;

    logic [WORD_W-1:0] win_q [DEPTH];
    logic [WORD_W-1:0] expanded;

    assign expanded = rotl(win_q[TAP_3] ^ win_q[TAP_8] ^ win_q[TAP_14] ^ win_q[0], 1);
    assign w_o      = use_ext_i ? ext_word_i : expanded;

    genvar k;
    generate
        for (k = 0; k < DEPTH - 1; k++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       win_q[k] <= '0;
                else if (shift_i) win_q[k] <= win_q[k+1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_q[DEPTH-1] <= '0;
        else if (shift_i) win_q[DEPTH-1] <= w_o;
    end

    // R3: the newest slot after a shift holds the word used by that round
    p_window_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> win_q[DEPTH-1] == $past(w_o));

endmodule

// File: rtl/sha1_round_logic.sv
module sha1_round_logic
    import sha1_pkg::*;
(
    input  hash_words_t       cur_i,
    input  logic [RND_W-1:0]  rnd_i,
    input  logic [WORD_W-1:0] w_i,
    output hash_words_t       nxt_o
);
    logic [WORD_W-1:0] temp;

    always_comb begin
        temp = rotl(cur_i.a, 5) + mix_f(rnd_i, cur_i.b, cur_i.c, cur_i.d)
             + cur_i.e + mix_k(rnd_i) + w_i;
        nxt_o.a = temp;
        nxt_o.b = cur_i.a;
        nxt_o.c = rotl(cur_i.b, 30);
        nxt_o.d = cur_i.c;
        nxt_o.e = cur_i.d;
    end

    always_comb begin
        assert (rnd_i <= RND_W'(N_ROUNDS)) else $error("p_round_range_r4: round index out of range");
    end

endmodule

// File: rtl/sha1_block_engine.sv
module sha1_block_engine
    import sha1_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   n_blocks_i,
    output logic               want_word_o,
    input  logic               word_valid_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic               done_o,
    output logic [5*WORD_W-1:0] digest_o
);
    localparam logic [RND_W-1:0] LAST_LOAD  = RND_W'(WIN_LEN - 1);
    localparam logic [RND_W-1:0] LAST_ROUND = RND_W'(N_ROUNDS - 1);

    eng_state_t        st_q, st_d;
    logic [RND_W-1:0]  round_q;
    logic [CNT_W-1:0]  blk_left_q;
    hash_words_t       work_q, hash_q, round_nxt, hash_sum;
    logic [WORD_W-1:0] w_cur;
    logic              advance, take_start;

    assign take_start = (st_q == S_IDLE) && start_i;
    assign advance    = ((st_q == S_LOAD) && word_valid_i) || (st_q == S_EXPAND);

    sha1_sched_window #(.DEPTH(WIN_LEN)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (advance),
        .use_ext_i (st_q == S_LOAD),
        .ext_word_i(word_i),
        .w_o       (w_cur)
    );

    sha1_round_logic u_round (
        .cur_i(work_q),
        .rnd_i(round_q),
        .w_i  (w_cur),
        .nxt_o(round_nxt)
    );

    always_comb begin
        hash_sum.a = hash_q.a + work_q.a;
        hash_sum.b = hash_q.b + work_q.b;
        hash_sum.c = hash_q.c + work_q.c;
        hash_sum.d = hash_q.d + work_q.d;
        hash_sum.e = hash_q.e + work_q.e;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_i) st_d = (n_blocks_i == '0) ? S_DONE : S_LOAD;
            S_LOAD:   if (word_valid_i && round_q == LAST_LOAD) st_d = S_EXPAND;
            S_EXPAND: if (round_q == LAST_ROUND) st_d = S_ACCUM;
            S_ACCUM:  st_d = (blk_left_q == CNT_W'(1)) ? S_DONE : S_LOAD;
            S_DONE:   st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        want_word_o = (st_q == S_LOAD);
        done_o      = (st_q == S_DONE);
        digest_o    = hash_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            round_q    <= '0;
            blk_left_q <= '0;
            work_q     <= HASH_IV;
            hash_q     <= HASH_IV;
        end else if (take_start) begin
            round_q    <= '0;
            blk_left_q <= n_blocks_i;
            work_q     <= HASH_IV;
            hash_q     <= HASH_IV;
        end else if (advance) begin
            round_q <= round_q + 1'b1;
            work_q  <= round_nxt;
        end else if (st_q == S_ACCUM) begin
            round_q    <= '0;
            blk_left_q <= blk_left_q - 1'b1;
            work_q     <= hash_sum;
            hash_q     <= hash_sum;
        end
    end

    // R2: an empty word slot leaves the round position and the request in place
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (want_word_o && !word_valid_i) |=> ($stable(round_q) && want_word_o));

    // R3: expansion rounds step by one each clock
    p_round_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXPAND) |=> (round_q == $past(round_q) + 1'b1));

    // R5: each accumulation consumes one block from the count
    p_block_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACCUM) |=> (blk_left_q == $past(blk_left_q) - 1'b1));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no hash change while idle without a start
    p_digest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || (st_q == S_IDLE && !start_i)) |=> $stable(digest_o));

    // R9: a start seen mid-message does not reload the count
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXPAND && start_i) |=> $stable(blk_left_q));

endmodule

// File: tb/sha1_block_engine_tb.sv
module sha1_block_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   nblk_in = '0;
    logic         want;
    logic         wvalid = 1'b0;
    logic [31:0]  word = '0;
    logic         done;
    logic [159:0] digest;

    int checks = 0;
    int fails  = 0;
    logic [31:0] blk [4][16];

    localparam logic [159:0] IV160 = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    always #4 clk = ~clk;

    sha1_block_engine #(.CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .n_blocks_i(nblk_in),
        .want_word_o(want), .word_valid_i(wvalid), .word_i(word),
        .done_o(done), .digest_o(digest)
    );

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // independent model: full 80-entry schedule per block
    function automatic logic [159:0] ref_digest(input int nb);
        logic [31:0] h [5];
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        for (int j = 0; j < nb; j++) begin
            for (int i = 0; i < 16; i++) w[i] = blk[j][i];
            for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
            a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
            for (int i = 0; i < 80; i++) begin
                if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
                else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
                else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
                else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
                t = rl(a, 5) + f + e + k + w[i];
                e = d; d = c; c = rl(b, 30); b = a; a = t;
            end
            h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
        end
        return {h[0], h[1], h[2], h[3], h[4]};
    endfunction

    // pad a byte string into blocks; returns block count
    function automatic int pad_msg(input string s);
        int len = s.len();
        int nb = (len + 8) / 64 + 1;
        logic [63:0] bits = 64'(len) * 8;
        for (int j = 0; j < 4; j++) for (int i = 0; i < 16; i++) blk[j][i] = '0;
        for (int p = 0; p < nb * 64; p++) begin
            logic [7:0] by;
            if (p < len) by = s[p];
            else if (p == len) by = 8'h80;
            else if (p >= nb * 64 - 8) by = bits[8*(nb*64-1-p) +: 8];
            else by = 8'h00;
            blk[p/64][(p%64)/4][8*(3-p%4) +: 8] = by;
        end
        return nb;
    endfunction

    task automatic run(input int nb, input bit stall, input int busy_at,
                       output int cyc, output logic [159:0] dg);
        int wc = 0;
        int k = 0;
        bit seen = 0;
        cyc = -1; dg = '0;
        @(negedge clk); start = 1'b1; nblk_in = 8'(nb);
        @(negedge clk); start = 1'b0;
        while (!seen && k < 3000) begin
            if (done) begin
                seen = 1; cyc = k; dg = digest;
            end else begin
                start   = (k == busy_at);
                nblk_in = (k == busy_at) ? 8'd3 : 8'(nb);
                if (want && !(stall && (k % 3 == 1))) begin
                    wvalid = 1'b1; word = blk[wc/16][wc%16]; wc++;
                end else begin
                    wvalid = 1'b0;
                end
                @(negedge clk); k++;
            end
        end
        wvalid = 1'b0; start = 1'b0;
        if (!seen) check("R6 watchdog", 160'(k), 160'(0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc, nb;
        logic [159:0] dg, ref_v;
        string s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset done", 160'(done), 160'(0));
        check("R1 reset want", 160'(want), 160'(0));
        check("R1 reset digest", digest, IV160);

        // R4 single block, known answer
        nb = pad_msg("abc");
        run(nb, 0, -1, cyc, dg);
        check("R4 abc digest", dg, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
        check("R6 one block timing", 160'(cyc), 160'(81));
        @(negedge clk);
        check("R7 done drops", 160'(done), 160'(0));
        repeat (5) @(negedge clk);
        check("R8 digest held", digest, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

        // R5 two blocks, known answer
        nb = pad_msg("abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq");
        run(nb, 0, -1, cyc, dg);
        check("R5 two block digest", dg, 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1);
        check("R6 two block timing", 160'(cyc), 160'(162));

        // R5/R6 three blocks (120 bytes)
        s = "";
        for (int i = 0; i < 120; i++) s = {s, string'(8'h30 + 8'(i % 40))};
        nb = pad_msg(s);
        check("R5 120 bytes pads to 3 blocks", 160'(nb), 160'(3));
        ref_v = ref_digest(nb);
        run(nb, 0, -1, cyc, dg);
        check("R5 three block digest", dg, ref_v);
        check("R6 three block timing", 160'(cyc), 160'(243));

        // R2 stalled word supply over four blocks
        s = "";
        for (int i = 0; i < 200; i++) s = {s, string'(8'h41 + 8'((i * 7) % 26))};
        nb = pad_msg(s);
        ref_v = ref_digest(nb);
        run(nb, 1, -1, cyc, dg);
        check("R2 stalled four block digest", dg, ref_v);
        check("R2 stalls add cycles", 160'(cyc > 324), 160'(1));

        // R9 start mid-run ignored
        nb = pad_msg("abc");
        run(nb, 0, 40, cyc, dg);
        check("R9 busy start digest", dg, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
        check("R9 busy start timing", 160'(cyc), 160'(81));

        // R10 empty message
        run(0, 0, -1, cyc, dg);
        check("R10 zero block timing", 160'(cyc), 160'(0));
        check("R10 zero block digest", dg, IV160);
        @(negedge clk);
        check("R7 zero block done drops", 160'(done), 160'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule